// File: doc/BRIEF.md
# Polyphonic Square-Wave Tone Mixer with Serial Note Control

The block produces up to eight square-wave voices at once and adds them into one unsigned sample stream sized for a single DAC. Each voice is a phase accumulator. A fixed increment is added on every clock, and the accumulator's top bit is the voice's square wave. Each increment register resets to a note of an A-major chord. Software can overwrite it through a simple write port to select any pitch, including pitches between standard notes.

Voices are switched on and off by single ASCII characters received on a serial line. The line uses 8 data bits, no parity and one stop bit, and defaults to 115200 baud. Mixed samples are registered on a sample strobe that runs at a fixed division of the clock. The strobe marks each new value for the DAC.

Top module: `tone_mixer_top`

## Requirements
- R1: After reset, `voice_on` is all zeros and `sample_out` is zero.
- R2: The receiver accepts 8N1 frames, least significant bit first, at CLK_HZ/BAUD clocks per bit. A character is acted on only when its stop bit is sampled high. A frame whose stop bit is low is dropped.
- R3: Characters '1' to '8' (0x31 to 0x38) set `voice_on[0]` to `voice_on[7]` respectively. A voice that is already on stays on.
- R4: Characters '!', '@', '#', '$', '%', '^', '&' and '*' clear `voice_on[0]` to `voice_on[7]` respectively. Clearing a voice that is already off changes nothing.
- R5: Character 'O' (0x4F) clears every bit of `voice_on`.
- R6: Every other character, including a frame with a low stop bit, leaves `voice_on` unchanged.
- R7: A write (`inc_wr` high at a clock edge) loads `inc_data` into the increment of the voice numbered `inc_sel` (0 is voice 1) and clears that voice's accumulator. Every clock without a write adds the increment to the accumulator modulo 2^32. The voice's square wave is bit 31 of the accumulator.
- R8: Every SAMPLE_DIV clocks, `sample_stb` pulses for one clock and `sample_out` takes the value 31 × (number of voices that are on and whose square wave is high). Its maximum is 248. `sample_out` changes only together with `sample_stb`.
- R9: The reset increments are floor(f·2^32 / CLK_HZ) for 110, 138.591, 164.814, 220, 277.183, 329.628, 440 and 554.365 Hz on voices 1 to 8. For example, voice 7 alone gives a 440 Hz square wave on `sample_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_rx | input | 1 | Serial command line, idle high |
| inc_wr | input | 1 | Increment write strobe |
| inc_sel | input | 3 | Voice number of the write, 0 to 7 |
| inc_data | input | 32 | New phase increment |
| voice_on | output | 8 | Enable state of each voice |
| sample_out | output | 8 | Mixed sample |
| sample_stb | output | 1 | One-clock pulse when `sample_out` is updated |

## Verification
The hardest state to reach from the ports is a mixed sample taken while several enabled voices are high at the same instant. With reset pitches, the voices drift out of phase, so the full 248 sum is rare and unpredictable. The stimulus writes a shared increment of 2^24 to every voice in consecutive cycles, which puts all voices nearly in phase with a 256-clock period. It then switches voices on one character at a time. A bench model tracks each voice's phase from its write cycle and predicts every strobed sample. Samples taken within a few clocks of a square-wave edge are skipped. A second pass leaves the reset pitches in place and counts the rising edges of voice 7 alone.

// File: rtl/tmx_pkg.sv
package tmx_pkg;

   localparam int unsigned MAX_VOICES = 8;

   typedef enum logic [1:0] {
      CMD_NONE    = 2'd0,
      CMD_ON      = 2'd1,
      CMD_OFF     = 2'd2,
      CMD_ALL_OFF = 2'd3
   } cmd_kind_e;

   typedef struct packed {
      cmd_kind_e  kind;
      logic [2:0] idx;
   } cmd_t;

   // Reset pitch of each voice in millihertz (A-major chord tones)
   function automatic longint unsigned reset_pitch_mhz(int unsigned idx);
      case (idx)
         0:       return 64'd110000;
         1:       return 64'd138591;
         2:       return 64'd164814;
         3:       return 64'd220000;
         4:       return 64'd277183;
         5:       return 64'd329628;
         6:       return 64'd440000;
         default: return 64'd554365;
      endcase
   endfunction

   // floor(f * 2^acc_w / clk_hz), with f in millihertz
   function automatic logic [63:0] pitch_to_inc(longint unsigned mhz,
                                                longint unsigned clk_hz,
                                                int unsigned acc_w);
      logic [63:0] num;
      num = 64'(mhz) << acc_w;
      return num / (64'(clk_hz) * 64'd1000);
   endfunction

   function automatic cmd_t decode_char(logic [7:0] c);
      cmd_t r;
      r.kind = CMD_NONE;
      r.idx  = 3'd0;
      if (c >= 8'h31 && c <= 8'h38) begin
         r.kind = CMD_ON;
         r.idx  = 3'(c - 8'h31);
      end else begin
         case (c)
            8'h21: begin r.kind = CMD_OFF; r.idx = 3'd0; end // !
            8'h40: begin r.kind = CMD_OFF; r.idx = 3'd1; end // @
            8'h23: begin r.kind = CMD_OFF; r.idx = 3'd2; end // #
            8'h24: begin r.kind = CMD_OFF; r.idx = 3'd3; end // $
            8'h25: begin r.kind = CMD_OFF; r.idx = 3'd4; end // %
            8'h5E: begin r.kind = CMD_OFF; r.idx = 3'd5; end // ^
            8'h26: begin r.kind = CMD_OFF; r.idx = 3'd6; end // &
            8'h2A: begin r.kind = CMD_OFF; r.idx = 3'd7; end // *
            8'h4F: r.kind = CMD_ALL_OFF;                      // O
            default: ;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/tmx_uart_rx.sv
module tmx_uart_rx #(
   parameter int unsigned CLKS_PER_BIT = 434,
   parameter int unsigned DATA_BITS    = 8,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx,
   output logic                 rx_valid,
   output logic [DATA_BITS-1:0] rx_byte
);

   localparam int unsigned CNT_W  = $clog2(CLKS_PER_BIT + 1);
   localparam int unsigned BIT_W  = $clog2(DATA_BITS + 1);
   localparam int unsigned HALF   = (CLKS_PER_BIT / 2 > 0) ? CLKS_PER_BIT / 2 : 1;

   if (CLKS_PER_BIT < 4) begin : g_bad_rate
      $error("tmx_uart_rx: CLKS_PER_BIT must be at least 4");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("tmx_uart_rx: SYNC_STAGES must be at least 1");
   end

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH
   } rx_state_e;

   rx_state_e            state;
   logic [CNT_W-1:0]     cnt;
   logic [BIT_W-1:0]     bitn;
   logic [DATA_BITS-1:0] shreg;
   logic                 rx_s;

   if (SYNC_STAGES == 1) begin : g_sync1
      logic s0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s0 <= 1'b1;
         else        s0 <= rx;
      end
      assign rx_s = s0;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2:0], rx};
      end
      assign rx_s = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         bitn     <= '0;
         shreg    <= '0;
         rx_valid <= 1'b0;
         rx_byte  <= '0;
      end else begin
         rx_valid <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (!rx_s) begin
                  state <= RX_START;
                  cnt   <= CNT_W'(HALF - 1);
               end
            end
            RX_START: begin
               if (cnt != '0) cnt <= cnt - 1'b1;
               else if (!rx_s) begin
                  state <= RX_DATA;
                  cnt   <= CNT_W'(CLKS_PER_BIT - 1);
                  bitn  <= '0;
               end else begin
                  state <= RX_IDLE;   // glitch, not a start bit
               end
            end
            RX_DATA: begin
               if (cnt != '0) cnt <= cnt - 1'b1;
               else begin
                  shreg <= {rx_s, shreg[DATA_BITS-1:1]};
                  cnt   <= CNT_W'(CLKS_PER_BIT - 1);
                  if (bitn == BIT_W'(DATA_BITS - 1)) state <= RX_STOP;
                  else                              bitn  <= bitn + 1'b1;
               end
            end
            RX_STOP: begin
               if (cnt != '0) cnt <= cnt - 1'b1;
               else if (rx_s) begin
                  rx_valid <= 1'b1;
                  rx_byte  <= shreg;
                  state    <= RX_IDLE;
               end else begin
                  state <= RX_WAIT_HIGH; // framing error: drop it
               end
            end
            RX_WAIT_HIGH: begin
               if (rx_s) state <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   a_r2_valid_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

endmodule

// File: rtl/tmx_cmd_decode.sv
module tmx_cmd_decode
   import tmx_pkg::*;
#(
   parameter int unsigned NUM_VOICES = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rx_valid,
   input  logic [7:0]            rx_byte,
   output logic [NUM_VOICES-1:0] voice_on
);

   cmd_t cmd;
   assign cmd = decode_char(rx_byte);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         voice_on <= '0;
      end else if (rx_valid) begin
         case (cmd.kind)
            CMD_ON:
               if (32'(cmd.idx) < NUM_VOICES) voice_on[cmd.idx] <= 1'b1;
            CMD_OFF:
               if (32'(cmd.idx) < NUM_VOICES) voice_on[cmd.idx] <= 1'b0;
            CMD_ALL_OFF: voice_on <= '0;
            default: ;
         endcase
      end
   end

   a_r3_first_on : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_byte == 8'h31 |=> voice_on[0]);

   a_r4_first_off : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_byte == 8'h21 |=> !voice_on[0]);

   a_r5_all_off : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_byte == 8'h4F |=> voice_on == '0);

   a_r6_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(voice_on));

endmodule

// File: rtl/tmx_voice.sv
module tmx_voice #(
   parameter int unsigned       ACC_W       = 32,
   parameter logic [ACC_W-1:0]  RESET_INC   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [ACC_W-1:0] inc_in,
   output logic             square
);

   logic [ACC_W-1:0] inc_q;
   logic [ACC_W-1:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inc_q <= RESET_INC;
         acc   <= '0;
      end else if (wr) begin
         inc_q <= inc_in;
         acc   <= '0;
      end else begin
         acc <= acc + inc_q;
      end
   end

   assign square = acc[ACC_W-1];

   a_r7_clear_on_write : assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> acc == '0);

   a_r7_load_on_write : assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> inc_q == $past(inc_in));

endmodule

// File: rtl/tmx_mixer.sv
module tmx_mixer #(
   parameter int unsigned NUM_VOICES = 8,
   parameter int unsigned OUT_W      = 8,
   parameter int unsigned SAMPLE_DIV = 1024
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_VOICES-1:0] square,
   input  logic [NUM_VOICES-1:0] enable,
   output logic [OUT_W-1:0]      sample_out,
   output logic                  sample_stb
);

   localparam int unsigned LEVEL  = ((1 << OUT_W) - 1) / NUM_VOICES;
   localparam int unsigned CNT_W  = $clog2(NUM_VOICES + 1);
   localparam int unsigned PEAK   = LEVEL * NUM_VOICES;

   if (LEVEL < 1) begin : g_bad_level
      $error("tmx_mixer: OUT_W too narrow for NUM_VOICES");
   end

   logic             tick;
   logic [CNT_W-1:0] n_high;
   logic [OUT_W-1:0] mix;

   if (SAMPLE_DIV <= 1) begin : g_every_clock
      assign tick = 1'b1;
   end else begin : g_divider
      localparam int unsigned DIV_W = $clog2(SAMPLE_DIV);
      logic [DIV_W-1:0] div_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  div_cnt <= '0;
         else if (div_cnt == DIV_W'(SAMPLE_DIV - 1))  div_cnt <= '0;
         else                                         div_cnt <= div_cnt + 1'b1;
      end
      assign tick = (div_cnt == DIV_W'(SAMPLE_DIV - 1));
   end

   always_comb begin
      n_high = '0;
      for (int i = 0; i < NUM_VOICES; i++) begin
         n_high = n_high + CNT_W'(square[i] & enable[i]);
      end
      mix = OUT_W'(n_high) * OUT_W'(LEVEL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_out <= '0;
         sample_stb <= 1'b0;
      end else begin
         sample_stb <= tick;
         if (tick) sample_out <= mix;
      end
   end

   a_r8_change_with_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sample_out) |-> sample_stb);

   a_r8_peak : assert property (@(posedge clk) disable iff (!rst_n)
      sample_out <= OUT_W'(PEAK));

   a_r8_quantised : assert property (@(posedge clk) disable iff (!rst_n)
      (32'(sample_out) % LEVEL) == 0);

endmodule

// File: rtl/tone_mixer_top.sv
module tone_mixer_top
   import tmx_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned BAUD        = 115_200,
   parameter int unsigned NUM_VOICES  = 8,
   parameter int unsigned ACC_W       = 32,
   parameter int unsigned OUT_W       = 8,
   parameter int unsigned SAMPLE_DIV  = 1024,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W      = (NUM_VOICES > 1) ? $clog2(NUM_VOICES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  uart_rx,
   input  logic                  inc_wr,
   input  logic [SEL_W-1:0]      inc_sel,
   input  logic [ACC_W-1:0]      inc_data,
   output logic [NUM_VOICES-1:0] voice_on,
   output logic [OUT_W-1:0]      sample_out,
   output logic                  sample_stb
);

   localparam int unsigned CLKS_PER_BIT = CLK_HZ / BAUD;

   if (NUM_VOICES < 1 || NUM_VOICES > MAX_VOICES) begin : g_bad_voices
      $error("tone_mixer_top: NUM_VOICES must be 1..8");
   end
   if (ACC_W < 8 || ACC_W > 32) begin : g_bad_acc
      $error("tone_mixer_top: ACC_W must be 8..32");
   end

   logic                  rx_valid;
   logic [7:0]            rx_byte;
   logic [NUM_VOICES-1:0] square;

   tmx_uart_rx #(
      .CLKS_PER_BIT (CLKS_PER_BIT),
      .DATA_BITS    (8),
      .SYNC_STAGES  (SYNC_STAGES)
   ) i_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx       (uart_rx),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte)
   );

   tmx_cmd_decode #(
      .NUM_VOICES (NUM_VOICES)
   ) i_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .voice_on (voice_on)
   );

   for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
      localparam logic [63:0] INC64 = pitch_to_inc(reset_pitch_mhz(v), CLK_HZ, ACC_W);
      tmx_voice #(
         .ACC_W     (ACC_W),
         .RESET_INC (INC64[ACC_W-1:0])
      ) i_voice (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr     (inc_wr && (32'(inc_sel) == v)),
         .inc_in (inc_data),
         .square (square[v])
      );
   end

   tmx_mixer #(
      .NUM_VOICES (NUM_VOICES),
      .OUT_W      (OUT_W),
      .SAMPLE_DIV (SAMPLE_DIV)
   ) i_mix (
      .clk        (clk),
      .rst_n      (rst_n),
      .square     (square),
      .enable     (voice_on),
      .sample_out (sample_out),
      .sample_stb (sample_stb)
   );

   a_r1_quiet_when_off : assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb && $past(voice_on) == '0 && $past(voice_on, 2) == '0 |-> sample_out == '0);

endmodule

// File: tb/test_tone_mixer_top.sv
module test_tone_mixer_top;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned CLK_HZ     = 1_152_000;
   localparam int unsigned BAUD       = 115_200;
   localparam int unsigned CPB        = CLK_HZ / BAUD;
   localparam int unsigned SDIV       = 8;
   localparam longint unsigned TEST_INC = 64'd1 << 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        uart_rx = 1'b1;
   logic        inc_wr = 1'b0;
   logic [2:0]  inc_sel = '0;
   logic [31:0] inc_data = '0;
   logic [7:0]  voice_on;
   logic [7:0]  sample_out;
   logic        sample_stb;

   int total = 0;
   int bad   = 0;
   longint unsigned cyc = 0;
   longint unsigned cw  [8];
   longint unsigned winc[8];
   bit              known[8];
   logic [7:0]      exp_mask = '0;
   bit              busy = 1'b1;
   bit              model_en = 1'b0;
   bit              done = 1'b0;
   logic [7:0]      mask_q[$];

   tone_mixer_top #(
      .CLK_HZ     (CLK_HZ),
      .BAUD       (BAUD),
      .SAMPLE_DIV (SDIV)
   ) i_tone_mixer_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .uart_rx    (uart_rx),
      .inc_wr     (inc_wr),
      .inc_sel    (inc_sel),
      .inc_data   (inc_data),
      .voice_on   (voice_on),
      .sample_out (sample_out),
      .sample_stb (sample_stb)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string req, longint unsigned act, longint unsigned exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_inc(int v, longint unsigned inc);
      @(negedge clk);
      inc_wr = 1'b1; inc_sel = 3'(v); inc_data = 32'(inc);
      @(posedge clk); #1;
      cw[v] = cyc; winc[v] = inc; known[v] = 1'b1;
      inc_wr = 1'b0;
   endtask

   // Driver: send one frame and push the mask the requirements predict
   task automatic send_char(logic [7:0] c, bit good_stop, logic [7:0] next_mask);
      busy = 1'b1;
      @(negedge clk);
      uart_rx = 1'b0;
      repeat (CPB) @(negedge clk);
      for (int b = 0; b < 8; b++) begin
         uart_rx = c[b];
         repeat (CPB) @(negedge clk);
      end
      uart_rx = good_stop;
      repeat (CPB) @(negedge clk);
      uart_rx = 1'b1;
      repeat (2 * CPB) @(negedge clk);
      exp_mask = next_mask;
      mask_q.push_back(next_mask);
      repeat (2) @(negedge clk);
      busy = 1'b0;
   endtask

   // Monitor: compare voice_on against queued masks, R3..R6 and R2
   always @(negedge clk) begin
      if (mask_q.size() > 0) begin
         logic [7:0] m;
         m = mask_q.pop_front();
         check("R2-R6 voice_on", voice_on, m);
      end
   end

   // Monitor: predict each strobed sample from the voice phase model (R7, R8)
   always @(negedge clk) begin
      if (sample_stb && model_en && !busy) begin
         bit skip;
         int n;
         skip = 1'b0; n = 0;
         for (int v = 0; v < 8; v++) begin
            if (exp_mask[v]) begin
               longint unsigned ph, low;
               if (!known[v]) skip = 1'b1;
               else begin
                  ph  = ((cyc - 1 - cw[v]) * winc[v]) & 64'hFFFF_FFFF;
                  low = ph & 64'h7FFF_FFFF;
                  if (low < 4 * winc[v] || low > 64'h8000_0000 - 4 * winc[v]) skip = 1'b1;
                  if (ph[31]) n++;
               end
            end
         end
         if (!skip) check("R8/R7 mixed sample", sample_out, 31 * n);
      end
   end

   initial begin
      int peak;
      int rises;
      logic [7:0] prev;
      for (int v = 0; v < 8; v++) begin known[v] = 1'b0; cw[v] = 0; winc[v] = 0; end
      repeat (5) @(negedge clk);
      check("R1 voice_on at reset", voice_on, 0);
      check("R1 sample_out at reset", sample_out, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check("R1 sample_out after reset", sample_out, 0);

      // R9: voice 7 alone at its reset pitch, count rising edges
      send_char("7", 1'b1, 8'h40);
      rises = 0; prev = sample_out;
      for (int k = 0; k < 26180; k++) begin
         @(negedge clk);
         if (prev == 0 && sample_out == 31) rises++;
         prev = sample_out;
      end
      total++;
      if (rises < 9 || rises > 11) begin
         bad++;
         $display("FAIL R9 440 Hz edge count: actual=%0d expected=10", rises);
      end
      send_char("O", 1'b1, 8'h00);                // R5

      // R7: common increment on all voices
      for (int v = 0; v < 8; v++) write_inc(v, TEST_INC);
      model_en = 1'b1;
      send_char("1", 1'b1, 8'h01);                // R3
      repeat (600) @(negedge clk);
      send_char("3", 1'b1, 8'h05);
      send_char("8", 1'b1, 8'h85);
      send_char("3", 1'b1, 8'h85);                // R3 repeat
      repeat (600) @(negedge clk);
      send_char("@", 1'b1, 8'h85);                // R4 off while off
      send_char("!", 1'b1, 8'h84);                // R4
      send_char("*", 1'b1, 8'h04);                // R4
      // R6: ignored characters
      send_char("A", 1'b1, 8'h04);
      send_char("9", 1'b1, 8'h04);
      send_char("0", 1'b1, 8'h04);
      send_char("o", 1'b1, 8'h04);
      // R2/R6: framing error drops '2'
      send_char("2", 1'b0, 8'h04);
      send_char("2", 1'b1, 8'h06);
      // R7: rewrite voice 2 with a faster pitch
      write_inc(1, TEST_INC * 2);
      repeat (600) @(negedge clk);
      write_inc(1, TEST_INC);
      // R8: all voices on, peak sum 248
      for (int v = 0; v < 8; v++) begin
         logic [7:0] m;
         m = exp_mask | (8'h01 << v);
         send_char(8'h31 + 8'(v), 1'b1, m);
      end
      peak = 0;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         if (sample_out > peak) peak = sample_out;
      end
      check("R8 peak with all voices on", peak, 248);
      send_char("%", 1'b1, 8'hEF);
      send_char("^", 1'b1, 8'hCF);
      send_char("&", 1'b1, 8'h8F);
      send_char("#", 1'b1, 8'h8B);
      send_char("$", 1'b1, 8'h83);
      repeat (400) @(negedge clk);
      send_char("O", 1'b1, 8'h00);                // R5
      repeat (40) @(negedge clk);
      check("R5 silent after all off", sample_out, 0);
      done = 1'b1;
   end

   initial begin
      for (int k = 0; k < 150000; k++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=done");
      end
      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule